// File: doc/BRIEF.md
# Crate Readout Event Builder

This controller sits on the front-end module of a detector crate and turns each level-1 accept into one framed event in the output FIFO that feeds the data-collector link. Every accept is counted in a small pending counter. While that counter is nonzero, the controller writes a header word and then walks the readout cards of the crate one after another by their 5-bit address. From each card it pulls six 16-bit hit words and then a 16-bit beam-clock counter word. It closes the event with a trailer word.

Cards are read over a shared 16-bit backplane bus. The controller places the card address on the bus and holds an active-low read strobe. The card answers with an active-low data-valid signal. If a card stays silent for too long, an error marker is written in its place and the walk continues with the next card. An almost-full flag from the FIFO holds the controller back, and no word is ever lost.

Top module: `crate_evt_builder`

## Requirements
- R1: Each event starts with a header word `{4'hC, crate_id[3:0], seq[7:0]}`. Nothing else is written for that event before it.
- R2: Cards are visited in ascending address order from 0 to NUM_CARDS-1. `bus_addr` holds the card being read and stays stable while `bus_rd_n` is low.
- R3: For each card that responds, exactly seven words are forwarded unmodified, in read order: six hit words, then the beam-clock counter word.
- R4: A bus word is taken only in a clock where both `bus_rd_n` and `bus_dv_n` are low. Once a word is taken, `bus_rd_n` goes high in the next cycle, so every read gets its own strobe.
- R5: A card's reply may take up to 15 cycles of waiting. If 16 consecutive clocks pass with `bus_rd_n` low and `bus_dv_n` high, the controller releases the strobe and writes the marker `{4'hF, 4'h0, word_index[2:0], card[4:0]}`. It skips the rest of that card.
- R6: Each event ends with the trailer `{4'hD, count[11:0]}`. The count is the number of words written for the event, header and trailer included.
- R7: A FIFO write takes place only when `fifo_afull` was low in the cycle before. Every word of every event still arrives, in order.
- R8: An `l1_accept` pulse raises the pending count and a completed event lowers it. When both happen in the same cycle the count is unchanged. The count saturates at 2^PEND_W-1, so accepts beyond that are dropped. An event starts only while the count is nonzero.
- R9: The header sequence number is 0 for the first event after reset, rises by one per event and wraps modulo 256.
- R10: During and right after reset `bus_rd_n` is high and `fifo_wr` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l1_accept | input | 1 | One-cycle level-1 accept pulse |
| crate_id | input | 4 | Crate identifier placed in headers |
| bus_addr | output | ADDR_W (5) | Card address on the backplane |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_dv_n | input | 1 | Active-low data valid from the addressed card |
| bus_data | input | 16 | Backplane data from the card |
| fifo_wr | output | 1 | FIFO write enable |
| fifo_data | output | 16 | Word written to the FIFO |
| fifo_afull | input | 1 | FIFO almost-full; stalls the controller |

## Verification
The pending counter can be raised by an accept pulse and lowered by an event's trailer in the same clock edge. The bench first times one event whose card latencies are known and the FIFO never stalls. It then places a second accept exactly on the edge where the first event's trailer is issued. The run passes only if exactly two complete events come out. A second overlap comes from stalls: almost-full is asserted at random while card replies are pending. Each write is checked against the almost-full value of the previous cycle, and the whole stream is compared word by word with frames the bench builds.

// File: rtl/ceb_pkg.sv
// Package for the crate event builder: the sequencer states, the word tags
// and the builders of header, trailer and error marker words.
// Assumes a 16-bit backplane and FIFO word.
package ceb_pkg;

    localparam int WORD_W = 16;

    localparam logic [3:0] TAG_HEAD  = 4'hC;
    localparam logic [3:0] TAG_TAIL  = 4'hD;
    localparam logic [3:0] TAG_FAULT = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_SETUP,
        ST_READ,
        ST_FAULT,
        ST_TAIL
    } ceb_state_e;

    // Header word: tag, crate identifier, event sequence number.
    function automatic logic [WORD_W-1:0] mk_head(input logic [3:0] crate,
                                                  input logic [7:0] seq);
        return {TAG_HEAD, crate, seq};
    endfunction

    // Trailer word: tag and the number of words in the event.
    function automatic logic [WORD_W-1:0] mk_tail(input logic [11:0] cnt);
        return {TAG_TAIL, cnt};
    endfunction

    // Error marker: tag, zero nibble, failing word index, card address.
    function automatic logic [WORD_W-1:0] mk_fault(input logic [2:0] widx,
                                                   input logic [4:0] card);
        return {TAG_FAULT, 4'h0, widx, card};
    endfunction

endpackage

// File: rtl/ceb_pending.sv
// Pending-accept counter. It rises on an accept pulse and falls when an
// event completes; when both happen in one cycle the count is unchanged.
// It saturates at its maximum, so accepts beyond that are dropped.
// Assumes inc and dec are single-cycle pulses.
module ceb_pending #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic nonzero
);
    logic [PEND_W-1:0] count;
    logic              at_max;

    assign at_max  = (count == {PEND_W{1'b1}});
    assign nonzero = (count != '0);

    // Update the count from the accept and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !dec && !at_max) begin
            count <= count + 1'b1;
        end else if (dec && !inc && nonzero) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/ceb_wr_stage.sv
// Output register stage toward the FIFO. Each write request from the
// sequencer becomes a registered write one cycle later.
// Assumes the request was only raised while almost-full was low.
module ceb_wr_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic [W-1:0] word,
    output logic         fifo_wr,
    output logic [W-1:0] fifo_data
);
    // Register the write strobe and its data word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_wr   <= 1'b0;
            fifo_data <= '0;
        end else begin
            fifo_wr <= req;
            if (req) begin
                fifo_data <= word;
            end
        end
    end
endmodule

// File: rtl/ceb_seq.sv
// Event sequencer. For each pending event it emits a header, walks the
// cards in ascending address order and makes HIT_WORDS+1 strobed reads of
// each. A card that stays silent for TIMEOUT cycles is replaced by an
// error marker. The event ends with a trailer.
// Assumes a card keeps data-valid low and its data stable for as long as
// the strobe is held low. Every write is requested only while almost-full
// is low.
module ceb_seq
    import ceb_pkg::*;
#(
    parameter int NUM_CARDS = 20,
    parameter int HIT_WORDS = 6,
    parameter int TIMEOUT   = 16,
    parameter int ADDR_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pending,
    input  logic [3:0]        crate_id,
    input  logic              bus_dv_n,
    input  logic [WORD_W-1:0] bus_data,
    input  logic              fifo_afull,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd_n,
    output logic              wr_req,
    output logic [WORD_W-1:0] wr_word,
    output logic              evt_done
);
    localparam int READS = HIT_WORDS + 1;
    localparam int IDX_W = (READS > 1) ? $clog2(READS) : 1;
    localparam int TMO_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

    ceb_state_e        state;
    logic [ADDR_W-1:0] card;
    logic [IDX_W-1:0]  widx;
    logic [TMO_W-1:0]  tmo;
    logic [11:0]       wcnt;
    logic [7:0]        seq;
    logic              last_word;
    logic              last_card;
    logic              got_word;
    logic              timed_out;

    assign last_word = (widx == IDX_W'(READS - 1));
    assign last_card = (card == ADDR_W'(NUM_CARDS - 1));
    assign got_word  = (state == ST_READ) && !bus_dv_n && !fifo_afull;
    assign timed_out = (state == ST_READ) && bus_dv_n && (tmo == TMO_W'(TIMEOUT - 1));
    assign bus_addr  = card;
    assign bus_rd_n  = (state != ST_READ);

    // Choose the write request and word for the current state.
    always_comb begin
        wr_req   = 1'b0;
        wr_word  = bus_data;
        evt_done = 1'b0;
        case (state)
            ST_HEAD: begin
                wr_req  = !fifo_afull;
                wr_word = mk_head(crate_id, seq);
            end
            ST_READ: begin
                wr_req  = got_word;
                wr_word = bus_data;
            end
            ST_FAULT: begin
                wr_req  = !fifo_afull;
                wr_word = mk_fault(3'(widx), 5'(card));
            end
            ST_TAIL: begin
                wr_req   = !fifo_afull;
                wr_word  = mk_tail(wcnt + 12'd1);
                evt_done = !fifo_afull;
            end
            default: ;
        endcase
    end

    // Advance the sequencer, the card and word indices, and the counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            card  <= '0;
            widx  <= '0;
            tmo   <= '0;
            wcnt  <= '0;
            seq   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pending) begin
                        state <= ST_HEAD;
                    end
                end
                ST_HEAD: begin
                    if (!fifo_afull) begin
                        card  <= '0;
                        widx  <= '0;
                        wcnt  <= 12'd1;
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (!fifo_afull) begin
                        tmo   <= '0;
                        state <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (got_word) begin
                        wcnt <= wcnt + 12'd1;
                        if (!last_word) begin
                            widx  <= widx + 1'b1;
                            state <= ST_SETUP;
                        end else if (last_card) begin
                            state <= ST_TAIL;
                        end else begin
                            widx  <= '0;
                            card  <= card + 1'b1;
                            state <= ST_SETUP;
                        end
                    end else if (timed_out) begin
                        state <= ST_FAULT;
                    end else if (bus_dv_n) begin
                        tmo <= tmo + 1'b1;
                    end
                end
                ST_FAULT: begin
                    if (!fifo_afull) begin
                        wcnt <= wcnt + 12'd1;
                        widx <= '0;
                        if (last_card) begin
                            state <= ST_TAIL;
                        end else begin
                            card  <= card + 1'b1;
                            state <= ST_SETUP;
                        end
                    end
                end
                ST_TAIL: begin
                    if (!fifo_afull) begin
                        seq   <= seq + 8'd1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/crate_evt_builder.sv
// Top of the crate event builder. It joins the pending-accept counter,
// the event sequencer and the registered FIFO write stage.
// Assumes a single-cycle l1_accept pulse and a FIFO whose almost-full
// flag leaves room for at least one word in flight.
module crate_evt_builder #(
    parameter int NUM_CARDS = 20,
    parameter int HIT_WORDS = 6,
    parameter int TIMEOUT   = 16,
    parameter int ADDR_W    = 5,
    parameter int PEND_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l1_accept,
    input  logic [3:0]        crate_id,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd_n,
    input  logic              bus_dv_n,
    input  logic [15:0]       bus_data,
    output logic              fifo_wr,
    output logic [15:0]       fifo_data,
    input  logic              fifo_afull
);
    logic        pending;
    logic        evt_done;
    logic        wr_req;
    logic [15:0] wr_word;

    ceb_pending #(.PEND_W(PEND_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (l1_accept),
        .dec     (evt_done),
        .nonzero (pending)
    );

    ceb_seq #(
        .NUM_CARDS (NUM_CARDS),
        .HIT_WORDS (HIT_WORDS),
        .TIMEOUT   (TIMEOUT),
        .ADDR_W    (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (pending),
        .crate_id   (crate_id),
        .bus_dv_n   (bus_dv_n),
        .bus_data   (bus_data),
        .fifo_afull (fifo_afull),
        .bus_addr   (bus_addr),
        .bus_rd_n   (bus_rd_n),
        .wr_req     (wr_req),
        .wr_word    (wr_word),
        .evt_done   (evt_done)
    );

    ceb_wr_stage #(.W(16)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (wr_req),
        .word      (wr_word),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data)
    );
endmodule

// File: rtl/ceb_chk.sv
// Protocol checker for the crate event builder, bound to the top.
// It watches only the bus and FIFO ports.
module ceb_chk #(
    parameter int NUM_CARDS = 20,
    parameter int TIMEOUT   = 16,
    parameter int ADDR_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd_n,
    input logic              bus_dv_n,
    input logic              fifo_afull,
    input logic              fifo_wr
);
    localparam int CW = $clog2(TIMEOUT + 2);

    logic [CW-1:0] wait_cnt;

    // Count consecutive strobed clocks that have no data-valid.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_rd_n || !bus_dv_n) begin
            wait_cnt <= '0;
        end else begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    // R7
    afull_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(!fifo_afull));

    // R4
    strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n && !bus_dv_n && !fifo_afull) |=> (bus_rd_n && fifo_wr));

    // R2
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n && $past(!bus_rd_n)) |-> $stable(bus_addr));

    // R5
    timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_cnt == CW'(TIMEOUT)) |-> bus_rd_n);

    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (int'(bus_addr) < NUM_CARDS));
endmodule

bind crate_evt_builder ceb_chk #(
    .NUM_CARDS (NUM_CARDS),
    .TIMEOUT   (TIMEOUT),
    .ADDR_W    (ADDR_W)
) u_ceb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd_n   (bus_rd_n),
    .bus_dv_n   (bus_dv_n),
    .fifo_afull (fifo_afull),
    .fifo_wr    (fifo_wr)
);

// File: tb/tb_crate_evt_builder.sv
module tb_crate_evt_builder;
    localparam int NC = 20;
    localparam int RD = 7;
    localparam int TMO = 16;
    localparam logic [3:0] CRATE = 4'h9;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        l1_accept;
    logic [4:0]  bus_addr;
    logic        bus_rd_n;
    logic        bus_dv_n;
    logic [15:0] bus_data;
    logic        fifo_wr;
    logic [15:0] fifo_data;
    logic        fifo_afull;

    always #2 clk = ~clk;

    crate_evt_builder dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .l1_accept  (l1_accept),
        .crate_id   (CRATE),
        .bus_addr   (bus_addr),
        .bus_rd_n   (bus_rd_n),
        .bus_dv_n   (bus_dv_n),
        .bus_data   (bus_data),
        .fifo_wr    (fifo_wr),
        .fifo_data  (fifo_data),
        .fifo_afull (fifo_afull)
    );

    int          lat [NC];
    int          kcard [NC];
    int          kexp [NC];
    logic [15:0] exp_q [$];
    string       tag_q [$];
    int          n_chk = 0;
    int          n_fail = 0;
    int          acc_cnt = 0;
    int          trl_seen = 0;
    logic [7:0]  seq_exp = 8'd0;
    int          cyc = 0;
    int          last_trl_cyc = 0;
    int          wcnt_bus = 0;
    int          last_c = 0;
    bit          afull_force = 0;
    bit          afull_rnd = 0;

    function automatic logic [15:0] card_word(input int c, input int k);
        return 16'((c * 2311 + k * 40503) ^ 23130);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Build the expected frame of one event from the current latencies.
    task automatic push_event();
        int n = 1;
        exp_q.push_back({4'hC, CRATE, seq_exp});
        tag_q.push_back("R1/R9 header");
        for (int c = 0; c < NC; c++) begin
            if (lat[c] >= TMO) begin
                exp_q.push_back({4'hF, 4'h0, 3'd0, 5'(c)});
                tag_q.push_back("R5 marker");
                n++;
            end else begin
                for (int i = 0; i < RD; i++) begin
                    exp_q.push_back(card_word(c, kexp[c] + i));
                    tag_q.push_back("R2/R3/R4 card word");
                end
                kexp[c] += RD;
                n += RD;
            end
        end
        exp_q.push_back({4'hD, 12'(n + 1)});
        tag_q.push_back("R6 trailer");
        seq_exp++;
    endtask

    always @(posedge clk) cyc++;

    // Monitor, card model and almost-full source, all at the falling edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && fifo_wr) begin
            chk(!fifo_afull, "R7 write after almost-full", 16'(fifo_afull), 16'd0);
            if (exp_q.size() == 0) begin
                chk(0, "R7 unexpected word", fifo_data, 16'h0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(fifo_data == e, t, fifo_data, e);
                if (t == "R6 trailer") begin
                    trl_seen++;
                    last_trl_cyc = cyc;
                end
            end
        end
        if (rst_n !== 1'b1) begin
            bus_dv_n = 1'b1;
            wcnt_bus = 0;
        end else if (!bus_rd_n) begin
            last_c = (int'(bus_addr) < NC) ? int'(bus_addr) : 0;
            wcnt_bus++;
            if (wcnt_bus > lat[last_c]) begin
                bus_dv_n = 1'b0;
                bus_data = card_word(last_c, kcard[last_c]);
            end
        end else begin
            if (!bus_dv_n) kcard[last_c]++;
            bus_dv_n = 1'b1;
            wcnt_bus = 0;
        end
        fifo_afull = afull_force | (afull_rnd && ($urandom % 4 == 0));
    end

    task automatic pulse(input bit push);
        @(negedge clk);
        l1_accept = 1'b1;
        if (push) begin
            push_event();
            acc_cnt++;
        end
        @(negedge clk);
        l1_accept = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || acc_cnt != trl_seen) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic set_lat(input int v);
        for (int c = 0; c < NC; c++) lat[c] = v;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int c0, c1, d, base;
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        l1_accept = 1'b0;
        bus_data = 16'h0;
        bus_dv_n = 1'b1;
        fifo_afull = 1'b0;
        for (int c = 0; c < NC; c++) begin
            kcard[c] = 0;
            kexp[c] = 0;
        end
        set_lat(1);
        repeat (5) @(negedge clk);
        chk(bus_rd_n == 1'b1, "R10 strobe in reset", 16'(bus_rd_n), 16'd1);
        chk(fifo_wr == 1'b0, "R10 write in reset", 16'(fifo_wr), 16'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus_rd_n == 1'b1, "R10 strobe after reset", 16'(bus_rd_n), 16'd1);
        chk(fifo_wr == 1'b0, "R8 no event without accept", 16'(fifo_wr), 16'd0);

        // R5 boundary: latency 15 is served, latency 16 gives a marker.
        lat[3] = 15;
        lat[4] = 16;
        pulse(1);
        wait_idle();

        // R8 coincidence: accept on the same edge as the trailer.
        set_lat(1);
        @(negedge clk);
        c0 = cyc;
        l1_accept = 1'b1;
        push_event();
        acc_cnt++;
        @(negedge clk);
        l1_accept = 1'b0;
        wait_idle();
        d = last_trl_cyc - c0;
        base = trl_seen;
        @(negedge clk);
        c1 = cyc;
        l1_accept = 1'b1;
        push_event();
        acc_cnt++;
        @(negedge clk);
        l1_accept = 1'b0;
        while (cyc < c1 + d - 1) @(negedge clk);
        l1_accept = 1'b1;
        push_event();
        acc_cnt++;
        @(negedge clk);
        l1_accept = 1'b0;
        wait_idle();
        chk(trl_seen - base == 2, "R8 coincident accept", 16'(trl_seen - base), 16'd2);

        // R8 saturation: 20 accepts while stalled, only 15 are kept.
        set_lat(0);
        afull_force = 1;
        base = trl_seen;
        for (int i = 0; i < 20; i++) pulse((acc_cnt - trl_seen) < 15);
        repeat (10) @(negedge clk);
        chk(trl_seen == base, "R7 no trailer while stalled", 16'(trl_seen - base), 16'd0);
        afull_force = 0;
        wait_idle();
        chk(trl_seen - base == 15, "R8 saturation", 16'(trl_seen - base), 16'd15);

        // Random latencies, silent cards and almost-full stalls.
        afull_rnd = 1;
        for (int g = 0; g < 5; g++) begin
            for (int c = 0; c < NC; c++)
                lat[c] = ($urandom % 8 == 0) ? 20 : int'($urandom % 5);
            for (int e = 0; e < 5; e++) begin
                repeat ($urandom % 30) @(negedge clk);
                pulse(1);
            end
            wait_idle();
        end
        afull_rnd = 0;

        // R9 wrap of the sequence number over many short events.
        set_lat(0);
        for (int e = 0; e < 230; e++) begin
            while (acc_cnt - trl_seen >= 14) @(negedge clk);
            pulse(1);
        end
        wait_idle();
        chk(exp_q.size() == 0, "R7 all words delivered", 16'(exp_q.size()), 16'd0);
        chk(seq_exp == 8'(trl_seen), "R9 event count", 16'(seq_exp), 16'(trl_seen));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule